// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A single-cycle start pulse, typically issued when the processor executes a start instruction, launches a conversion. The sequencer drives a trial code to an external digital-to-analog converter and reads back one comparator bit. That bit says whether the analog input lies above the voltage the trial code produces. The sequencer decides one bit per step, from the most significant bit down to the least significant.

Every conversion takes a fixed number of clock cycles. With the default parameters this is 2 setup cycles plus 10 steps of 6 cycles, 62 cycles in all. At the end the final code stays in the code register, and a sticky completion flag rises. The flag also serves as the interrupt request. The flag stays set until a clear pulse arrives or a new conversion starts. The DAC, the comparator, sample-and-hold and input selection are outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `sar_code_o` is all zeros.
- R2: A `start_i` pulse while idle makes `busy_o` 1, `done_o` 0 and `sar_code_o` all zeros in the next cycle.
- R3: After the setup cycles (2 by default), the MSB of `sar_code_o` is 1 and all other bits are 0. With the defaults this is 0x200, visible from the third cycle after the start edge.
- R4: Each step lasts 6 cycles, and `cmp_above_i` is sampled only on the last cycle of the step. On that edge the bit under trial stays 1 if `cmp_above_i` is 1 and is cleared if it is 0. On the same edge the next lower bit is set to 1. Values of `cmp_above_i` in other cycles have no effect.
- R5: Bits are resolved from bit 9 down to bit 0. With a comparator that reports 1 whenever the trial code is at or below a target value, the final code equals that target, for every target from 0 to 1023.
- R6: `done_o` becomes 1 on exactly the 62nd rising edge after the start edge. On that same edge `busy_o` becomes 0. In the cycles between, `busy_o` is 1 and `done_o` is 0.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. This holds even on the completing edge: the code sequence, the result and the completion time do not change.
- R8: `done_o` stays 1 until `clr_done_i` is pulsed, and is 0 in the following cycle. The clear does not change `sar_code_o`.
- R9: Starting a new conversion while `done_o` is 1 clears `done_o` in the next cycle.
- R10: If `clr_done_i` arrives on the same edge that completes a conversion, the completion wins and `done_o` becomes 1.
- R11: While idle, `sar_code_o` holds the last result, whatever `cmp_above_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion start pulse |
| clr_done_i | input | 1 | One-cycle clear of the completion flag |
| cmp_above_i | input | 1 | Comparator: 1 when the analog input is above the trial voltage |
| sar_code_o | output | 10 | Trial code to the DAC; the result once `done_o` is 1 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Sticky completion flag and interrupt request |

## Verification
The bench checks the extreme codes 0 and 1023, where a sequencer with an off-by-one bit index would leave the LSB set or drop the MSB. It also checks alternating and random targets, comparing the partial code after every step. In one test the comparator toggles randomly outside the sampling cycles, so a design that samples on the wrong phase converges to a wrong code. Further tests pulse start mid-conversion and on the completing edge, and pulse clear on the completing edge. A design with the wrong priority would restart, end early, or lose the flag in these tests.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int SAR_RES_DEF   = 10;
   localparam int SAR_SETUP_DEF = 2;
   localparam int SAR_STEP_DEF  = 6;

   function automatic int sar_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sar_pacer.sv
module sar_pacer
   import sar_pkg::*;
#(
   parameter int RES_BITS  = SAR_RES_DEF,
   parameter int SETUP_CYC = SAR_SETUP_DEF,
   parameter int STEP_CYC  = SAR_STEP_DEF,
   localparam int IDX_W    = $clog2(RES_BITS),
   localparam int PH_W     = $clog2(sar_max(SETUP_CYC, STEP_CYC) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   output logic             busy_o,
   output logic             seed_o,
   output logic             commit_o,
   output logic             final_o,
   output logic [IDX_W-1:0] bit_idx_o
);
   localparam logic [PH_W-1:0]  SETUP_LAST = PH_W'(SETUP_CYC - 1);
   localparam logic [PH_W-1:0]  STEP_LAST  = PH_W'(STEP_CYC - 1);
   localparam logic [IDX_W-1:0] IDX_TOP    = IDX_W'(RES_BITS - 1);

   logic             busy_q;
   logic             setup_q;
   logic [PH_W-1:0]  phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             phase_last;

   assign phase_last = setup_q ? (phase_q == SETUP_LAST) : (phase_q == STEP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         setup_q <= 1'b0;
         phase_q <= '0;
         idx_q   <= '0;
      end else if (launch_i) begin
         busy_q  <= 1'b1;
         setup_q <= 1'b1;
         phase_q <= '0;
         idx_q   <= IDX_TOP;
      end else if (busy_q) begin
         phase_q <= phase_last ? '0 : phase_q + 1'b1;
         if (phase_last) begin
            if (setup_q) begin
               setup_q <= 1'b0;
            end else if (idx_q == '0) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q - 1'b1;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign seed_o    = busy_q & setup_q & phase_last;
   assign commit_o  = busy_q & ~setup_q & phase_last;
   assign final_o   = commit_o & (idx_q == '0);
   assign bit_idx_o = idx_q;

   // R5: bits are resolved strictly downward, one per step
   assert_idx_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o && idx_q != '0 && !launch_i) |=> (idx_q == $past(idx_q) - 1'b1));

   // R4: no step completes until a full step length has elapsed after seeding
   assert_no_commit_after_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seed_o |=> !commit_o);
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
   parameter int RES_BITS = 10,
   localparam int IDX_W   = $clog2(RES_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch_i,
   input  logic                seed_i,
   input  logic                commit_i,
   input  logic [IDX_W-1:0]    bit_idx_i,
   input  logic                cmp_above_i,
   output logic [RES_BITS-1:0] code_o
);
   logic [RES_BITS-1:0] code_q;

   for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
      logic trial_next;
      if (i < RES_BITS - 1) begin : g_has_upper
         assign trial_next = commit_i && (bit_idx_i == IDX_W'(i + 1));
      end else begin : g_top
         assign trial_next = seed_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[i] <= 1'b0;
         end else if (launch_i) begin
            code_q[i] <= 1'b0;
         end else if (commit_i && (bit_idx_i == IDX_W'(i))) begin
            code_q[i] <= cmp_above_i;
         end else if (trial_next) begin
            code_q[i] <= 1'b1;
         end
      end
   end

   assign code_o = code_q;

   // R2: a launch always leaves the code cleared
   assert_launch_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> (code_o == '0));

   // R11: with no launch, seed or commit the code does not move
   assert_hold_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch_i && !seed_i && !commit_i) |=> $stable(code_o));

   // R4: a commit changes at most the decided bit and the next lower bit
   assert_commit_two_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !launch_i) |=> ($countones(code_o ^ $past(code_o)) <= 2));
endmodule

// File: rtl/sar_done_flag.sv
module sar_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic done_o
);
   logic done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (set_i)  done_q <= 1'b1;
      else if (clr_i)  done_q <= 1'b0;
   end

   assign done_o = done_q;

   // R8: the flag is sticky without a clear
   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_i) |=> done_q);

   // R8: a clear without a completion drops the flag
   assert_clr_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !done_q);

   // R10: completion wins over a simultaneous clear
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> done_q);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_pkg::*;
#(
   parameter int RES_BITS  = SAR_RES_DEF,
   parameter int SETUP_CYC = SAR_SETUP_DEF,
   parameter int STEP_CYC  = SAR_STEP_DEF,
   localparam int IDX_W    = $clog2(RES_BITS),
   localparam int CONV_CYC = SETUP_CYC + RES_BITS * STEP_CYC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                clr_done_i,
   input  logic                cmp_above_i,
   output logic [RES_BITS-1:0] sar_code_o,
   output logic                busy_o,
   output logic                done_o
);
   if (RES_BITS < 2) begin : g_bad_res
      $error("sar_conv_ctrl: RES_BITS must be at least 2");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("sar_conv_ctrl: SETUP_CYC must be at least 1");
   end
   if (STEP_CYC < 2) begin : g_bad_step
      $error("sar_conv_ctrl: STEP_CYC must be at least 2");
   end
   if (CONV_CYC < RES_BITS) begin : g_bad_conv
      $error("sar_conv_ctrl: conversion length inconsistent");
   end

   logic             busy;
   logic             launch;
   logic             seed;
   logic             commit;
   logic             fin;
   logic [IDX_W-1:0] bit_idx;

   assign launch = start_i & ~busy;

   sar_pacer #(
      .RES_BITS (RES_BITS),
      .SETUP_CYC(SETUP_CYC),
      .STEP_CYC (STEP_CYC)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .busy_o   (busy),
      .seed_o   (seed),
      .commit_o (commit),
      .final_o  (fin),
      .bit_idx_o(bit_idx)
   );

   sar_code_reg #(
      .RES_BITS(RES_BITS)
   ) u_code (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .seed_i     (seed),
      .commit_i   (commit),
      .bit_idx_i  (bit_idx),
      .cmp_above_i(cmp_above_i),
      .code_o     (sar_code_o)
   );

   sar_done_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fin),
      .clr_i (clr_done_i | launch),
      .done_o(done_o)
   );

   assign busy_o = busy;

   // R7: a start during a conversion does not end or restart it
   assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && !fin) |=> (busy && !$stable(sar_code_o) || busy));

   // R6: busy ends on exactly the edge the flag rises
   assert_done_at_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_o);

   // R6: the flag cannot rise while still busy
   assert_no_done_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !busy);

   // R9: a start from idle drops the flag
   assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy) |=> (!done_o && busy));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
   localparam int RES = 10;
   localparam int CONV = 62;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           clr_done_i = 1'b0;
   logic           cmp_w;
   logic [RES-1:0] code;
   logic           busy, done;

   logic [RES-1:0] tgt_q = '0;
   logic           use_noise = 1'b0;
   logic           noise_val = 1'b0;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   // comparator: input sits half an LSB above the target code
   assign cmp_w = use_noise ? noise_val : (code <= tgt_q);

   sar_conv_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_done_i(clr_done_i),
      .cmp_above_i(cmp_w), .sar_code_o(code), .busy_o(busy), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one full conversion; poke_at = edge number at which a stray start lands
   task automatic run_conv(input logic [RES-1:0] tgt, input bit noise,
                           input int poke_at, input bit clr_at_end);
      int win_err = 0;
      int step_err = 0;
      int step_act = 0;
      int step_exp = 0;
      tgt_q = tgt;
      @(negedge clk);
      start_i = 1'b1;
      use_noise = 1'b0;
      @(posedge clk);                       // start edge E0
      for (int n = 1; n <= CONV; n++) begin
         @(negedge clk);                    // state after edge n-1
         start_i = (n == poke_at);
         clr_done_i = clr_at_end && (n == CONV);
         if (n == 1)
            chk(code == '0 && busy && !done, "R2", "state after start",
                {busy, done, code}, {2'b10, 10'h000});
         if (n == 3)
            chk(code == 10'h200, "R3", "seed code after setup", code, 10'h200);
         if (!(busy && !done)) win_err++;
         if (n >= 9 && n < CONV && ((n - 9) % 6) == 0) begin
            int k = (n - 9) / 6;
            logic [RES-1:0] mask = ~((10'h200 >> k) - 10'h001);
            logic [RES-1:0] e = (tgt & mask) | (10'h100 >> k);
            if (code != e) begin
               step_err++;
               step_act = code;
               step_exp = e;
            end
         end
         if (noise && !(n >= 8 && ((n - 8) % 6) == 0)) begin
            use_noise = 1'b1;
            noise_val = 1'($urandom);
         end else begin
            use_noise = 1'b0;
         end
      end
      @(posedge clk);                       // edge 62
      @(negedge clk);
      start_i = 1'b0;
      clr_done_i = 1'b0;
      use_noise = 1'b0;
      chk(win_err == 0, "R6", "busy high / done low through conversion", win_err, 0);
      chk(step_err == 0, "R4", "partial code after each step", step_act, step_exp);
      chk(done && !busy, "R6", "done at edge 62", {busy, done}, 2'b01);
      chk(code == tgt, "R5", "final code", code, tgt);
   endtask

   task automatic test_reset();
      chk(!busy && !done && code == '0, "R1", "reset state", {busy, done, code}, 0);
   endtask

   task automatic test_fixed();
      logic [RES-1:0] pats[7] = '{10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h001, 10'h200, 10'h1FF};
      foreach (pats[i]) run_conv(pats[i], 1'b0, 0, 1'b0);
   endtask

   task automatic test_random();
      for (int i = 0; i < 20; i++) run_conv(10'($urandom), 1'b0, 0, 1'b0);
   endtask

   task automatic test_noise();   // R4: off-sample comparator values ignored
      run_conv(10'h2C7, 1'b1, 0, 1'b0);
      run_conv(10'h0E3, 1'b1, 0, 1'b0);
   endtask

   task automatic test_start_busy();   // R7
      run_conv(10'h19B, 1'b0, 30, 1'b0);
      chk(done, "R7", "mid start ignored, done kept", done, 1);
      run_conv(10'h36D, 1'b0, CONV, 1'b0);
      chk(!busy && done && code == 10'h36D, "R7", "start on final edge ignored",
          {busy, done, code}, {2'b01, 10'h36D});
   endtask

   task automatic test_sticky_clear();   // R8, R11
      run_conv(10'h0F0, 1'b0, 0, 1'b0);
      begin
         int bad = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            use_noise = 1'b1;
            noise_val = 1'($urandom);
            if (!done || code != 10'h0F0 || busy) bad++;
         end
         use_noise = 1'b0;
         chk(bad == 0, "R11", "idle hold of flag and code", bad, 0);
      end
      @(negedge clk); clr_done_i = 1'b1;
      @(negedge clk); clr_done_i = 1'b0;
      chk(!done && code == 10'h0F0, "R8", "clear drops flag, keeps code",
          {done, code}, {1'b0, 10'h0F0});
   endtask

   task automatic test_restart();   // R9
      run_conv(10'h321, 1'b0, 0, 1'b0);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(!done && busy && code == '0, "R9", "restart clears flag",
          {busy, done, code}, {2'b10, 10'h000});
      repeat (70) @(negedge clk);
   endtask

   task automatic test_clr_vs_done();   // R10
      run_conv(10'h2E1, 1'b0, 0, 1'b1);
      chk(done, "R10", "completion beats clear", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_fixed();
      test_random();
      test_noise();
      test_start_busy();
      test_sticky_clear();
      test_restart();
      test_clr_vs_done();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule